// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block generates the address for one port of a banked memory. It holds an 18-bit address made of a 6-bit bank number in the upper bits and a 12-bit offset within the bank in the lower bits. On each rising clock edge it picks one of four operations: it takes an external address, it steps forward by one, it keeps its value, or it returns to the address most recently taken from outside. A second register, the anchor, keeps that most recently taken external address so that a burst can be replayed from its start.

The operation is chosen by three active-low strobes: `load_n`, `step_n` and `replay_n`. The decoder in `bac_op_decode` maps them onto an enumerated operation with four named values. `OP_REPLAY` is chosen whenever `replay_n` is low. Otherwise `OP_LOAD` is chosen when `load_n` is low. Otherwise `OP_STEP` is chosen when `step_n` is low. Otherwise the operation is `OP_HOLD`. The transitions of the address register are these four, plus reset, which moves it to zero. When the counter steps, a carry out of the offset moves the address to offset 0 of the next bank, and the last bank wraps to bank 0. The block has no chip-select or byte-select input, so nothing of that kind can affect its stepping. Memory array access and data paths are outside this block.

Top module: `burst_addr_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge, both the address and the anchor become 0. The bench sees this on `addr_o`, and through a replay that it issues later.
- R2: When `replay_n` is high and `load_n` is low at a rising edge, `addr_o` takes the value of `ext_addr` sampled at that edge.
- R3: When `replay_n`, `load_n` and `step_n` are high, high and low at a rising edge, `addr_o` increases by one. The offset is in bits 11:0 and the bank is in bits 17:12. An offset of FFFh carries to offset 0 of the next bank.
- R4: Stepping from address 3FFFFh (bank 63, offset FFFh) gives address 0.
- R5: When all three strobes are high at a rising edge, `addr_o` keeps its value.
- R6: When `replay_n` is low at a rising edge, `addr_o` takes the anchor value held before that edge. This happens whatever `load_n` and `step_n` are doing.
- R7: Every rising edge with `load_n` low stores `ext_addr` in the anchor, including an edge where `replay_n` is also low. At other edges the anchor keeps its value.
- R8: Load takes precedence over step. With `replay_n` high and both `load_n` and `step_n` low, `addr_o` takes `ext_addr`.
- R9: `addr_o` is registered. It changes only at the rising edge where the strobes are sampled, and is steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | 18 | External address: bank in bits 17:12, offset in bits 11:0 |
| load_n | input | 1 | Take the external address, active low |
| step_n | input | 1 | Advance by one, active low |
| replay_n | input | 1 | Return to the anchor address, active low |
| addr_o | output | 18 | Current address |

## Verification
Every result of this block is due one rising edge after the strobes that cause it. The bench drives inputs on the falling edge and compares `addr_o` on the next falling edge, so exactly one register lies between stimulus and check. The anchor has no port of its own. Its contents become visible one edge after a replay, so an anchor check needs two operations: the one that writes the anchor and the replay that reads it. Each of these is compared at its own falling edge.

// File: rtl/bac_pkg.sv
package bac_pkg;
    parameter int BANK_BITS = 6;
    parameter int OFS_BITS  = 12;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_STEP   = 2'd1,
        OP_LOAD   = 2'd2,
        OP_REPLAY = 2'd3
    } op_e;
endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
    import bac_pkg::*;
(
    input  logic load_n,
    input  logic step_n,
    input  logic replay_n,
    output op_e  op
);
    // Priority: replay, then load, then step, else hold (R6, R8)
    always_comb begin
        if (!replay_n)    op = OP_REPLAY;
        else if (!load_n) op = OP_LOAD;
        else if (!step_n) op = OP_STEP;
        else              op = OP_HOLD;
    end

    always_comb begin
        assert (replay_n || op == OP_REPLAY) else $error("AST_REPLAY_WINS"); // R6
    end
endmodule

// File: rtl/bac_wrap_inc.sv
module bac_wrap_inc #(
    parameter int BANK_W = bac_pkg::BANK_BITS,
    parameter int OFS_W  = bac_pkg::OFS_BITS
) (
    input  logic [BANK_W+OFS_W-1:0] cur,
    output logic [BANK_W+OFS_W-1:0] nxt
);
    localparam int AW = BANK_W + OFS_W;

    logic [OFS_W:0] ofs_sum;
    assign ofs_sum = {1'b0, cur[OFS_W-1:0]} + {{OFS_W{1'b0}}, 1'b1};

    generate
        if (BANK_W > 0) begin : g_banked
            logic [BANK_W-1:0] bank_nxt;
            // Carry from offset into bank; last bank wraps to 0 (R3, R4)
            assign bank_nxt = cur[AW-1:OFS_W] + {{(BANK_W-1){1'b0}}, ofs_sum[OFS_W]};
            assign nxt      = {bank_nxt, ofs_sum[OFS_W-1:0]};
        end else begin : g_flat
            assign nxt = ofs_sum[OFS_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/bac_anchor.sv
module bac_anchor #(
    parameter int AW = bac_pkg::BANK_BITS + bac_pkg::OFS_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [AW-1:0] cap_val,
    output logic [AW-1:0] anchor_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      anchor_q <= '0;
        else if (cap_en) anchor_q <= cap_val;
    end

    AST_ANCHOR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> anchor_q == $past(cap_val)) else $error("AST_ANCHOR_CAPTURE"); // R7
    AST_ANCHOR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(anchor_q)) else $error("AST_ANCHOR_KEEP"); // R7
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
    import bac_pkg::*;
#(
    parameter int BANK_W = BANK_BITS,
    parameter int OFS_W  = OFS_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BANK_W+OFS_W-1:0] ext_addr,
    input  logic                    load_n,
    input  logic                    step_n,
    input  logic                    replay_n,
    output logic [BANK_W+OFS_W-1:0] addr_o
);
    localparam int AW = BANK_W + OFS_W;

    op_e           op;
    logic [AW-1:0] cnt_q, cnt_d, inc_val, anchor_q;

    bac_op_decode u_dec (
        .load_n   (load_n),
        .step_n   (step_n),
        .replay_n (replay_n),
        .op       (op)
    );

    bac_wrap_inc #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_inc (
        .cur (cnt_q),
        .nxt (inc_val)
    );

    // Anchor takes every external load, even under replay (R7)
    bac_anchor #(.AW(AW)) u_anchor (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (!load_n),
        .cap_val  (ext_addr),
        .anchor_q (anchor_q)
    );

    always_comb begin
        unique case (op)
            OP_REPLAY: cnt_d = anchor_q;
            OP_LOAD:   cnt_d = ext_addr;
            OP_STEP:   cnt_d = inc_val;
            OP_HOLD:   cnt_d = cnt_q;
            default:   cnt_d = cnt_q;
        endcase
    end

    // State register (R1, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Output process
    always_comb addr_o = cnt_q;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_n && !load_n) |=> addr_o == $past(ext_addr)) else $error("AST_LOAD_TAKES"); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_n && load_n && !step_n) |=> addr_o == AW'($past(addr_o) + 1'b1)) else $error("AST_STEP_ONE"); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_n && load_n && step_n) |=> $stable(addr_o)) else $error("AST_HOLD_STABLE"); // R5
    AST_REPLAY_ANCHOR: assert property (@(posedge clk) disable iff (!rst_n)
        !replay_n |=> addr_o == $past(anchor_q)) else $error("AST_REPLAY_ANCHOR"); // R6
endmodule

// File: tb/tb_burst_addr_counter.sv
module tb_burst_addr_counter;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          load_n = 1'b1, step_n = 1'b1, replay_n = 1'b1;
    logic [AW-1:0] addr_o;

    int vectors = 0;
    int misses  = 0;
    logic [AW-1:0] m_addr = '0, m_anchor = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_counter dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .load_n(load_n), .step_n(step_n), .replay_n(replay_n), .addr_o(addr_o)
    );

    function automatic logic [AW-1:0] model_next(logic [AW-1:0] cur, logic [AW-1:0] anc,
                                                 logic ld, logic st, logic rp, logic [AW-1:0] ext);
        if (!rp)      return anc;
        else if (!ld) return ext;
        else if (!st) return cur + 1'b1;
        else          return cur;
    endfunction

    task automatic check(string req, logic [AW-1:0] exp);
        vectors++;
        if (addr_o !== exp) begin
            misses++;
            $display("FAIL %s: addr_o=%05h expected=%05h", req, addr_o, exp);
        end
    endtask

    // Drive after a falling edge, update model at the rising edge, compare at the next falling edge
    task automatic op(string req, logic ld, logic st, logic rp, logic [AW-1:0] ext);
        load_n = ld; step_n = st; replay_n = rp; ext_addr = ext;
        @(posedge clk);
        if (!rst_n) begin
            m_addr = '0; m_anchor = '0;
        end else begin
            m_addr = model_next(m_addr, m_anchor, ld, st, rp, ext);
            if (!ld) m_anchor = ext;
        end
        @(negedge clk);
        check(req, m_addr);
    endtask

    initial begin
        void'($urandom(32'd5618));
        @(negedge clk);
        rst_n = 1'b0;
        op("R1 reset", 1'b0, 1'b0, 1'b1, 18'h2ABCD);
        rst_n = 1'b1;
        op("R1 anchor cleared", 1'b1, 1'b1, 1'b0, 18'h11111);
        op("R2 load", 1'b0, 1'b1, 1'b1, 18'h05FFF);
        op("R3 bank carry", 1'b1, 1'b0, 1'b1, 18'h00000);
        check("R3 bank6 ofs0", 18'h06000);
        op("R5 hold", 1'b1, 1'b1, 1'b1, 18'h3FFFF);
        #7 check("R9 steady between edges", 18'h06000);
        @(negedge clk);
        op("R6 replay", 1'b1, 1'b0, 1'b0, 18'h12345);
        op("R2 load top", 1'b0, 1'b1, 1'b1, 18'h3FFFF);
        op("R4 wrap", 1'b1, 1'b0, 1'b1, 18'h0);
        check("R4 zero", 18'h00000);
        op("R8 load over step", 1'b0, 1'b0, 1'b1, 18'h00ABC);
        op("R6 replay over load", 1'b0, 1'b1, 1'b0, 18'h22222);
        check("R6 old anchor", 18'h00ABC);
        op("R7 anchor updated under replay", 1'b1, 1'b1, 1'b0, 18'h0);
        check("R7 new anchor", 18'h22222);
        for (int i = 0; i < 2000; i++) begin
            logic [2:0] pick;
            pick = 3'($urandom);
            op("R2/R3/R5/R6/R7 random", pick[0], pick[1] & ($urandom % 8 != 0), pick[2] | ($urandom % 3 != 0),
               ($urandom % 4 == 0) ? {6'($urandom), 12'hFFF} : 18'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule